// File: doc/BRIEF.md
# SIMD Branch Divergence Mask Stack

This block keeps track of which lanes of a 32-lane SIMD group stay enabled after the lanes disagree on a conditional branch. When a branch strobe arrives, the per-lane predicate vector is saved as a lane mask. The reconvergence address that comes with the branch is saved alongside it. Mask and address sit in two separate stacks that always move together, so entry N of one belongs to entry N of the other.

The sequencer presents its program counter every cycle. When that counter equals the address on top of the address stack, the top entries of both stacks are removed. An explicit pop input does the same thing without an address match. The lane mask driven to the datapath is the AND of the two top masks. It reduces to the top mask alone when only one entry is held, and to all ones when the stacks are empty. A separate flag tells the sequencer that no lane is enabled, so it can skip the instruction.

Top module: `lane_mask_stack`

## Requirements
- R1: A synchronous active-high reset empties both stacks and clears the overflow and underflow flags. After reset the active mask is all ones and the reconvergence target is zero.
- R2: A branch strobe on a stack that is not full, with no pop in the same cycle, pushes the predicate vector and the branch target. From the next cycle the reconvergence target output equals the pushed target.
- R3: With two or more entries held, the active mask is the bitwise AND of the top mask and the mask just below it. With exactly one entry it is the top mask. Bit i of every mask belongs to lane i.
- R4: When the stack is not empty and the program counter equals the reconvergence target output, the top mask and top address are removed together at the next clock edge.
- R5: An explicit pop request removes the top entries. A pop request on an empty stack changes nothing else and sets the underflow flag, which then stays set until reset.
- R6: A branch strobe on a full stack (DEPTH entries) with no pop in the same cycle is dropped. The stack contents are unchanged, and the overflow flag is set and stays set until reset.
- R7: When a pop (matched or requested) and a push fall in the same cycle, the pop is applied first and the push second. On a non-empty stack the depth is unchanged and the new entry replaces the old top. A full stack does not overflow in that case.
- R8: The all-inactive output is high exactly when the active mask is zero.
- R9: While the stack is empty the reconvergence target output is zero and the active mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Divergent branch strobe; pushes one entry |
| br_pred | input | LANES | Per-lane predicate, bit i for lane i |
| br_target | input | AW | Reconvergence address pushed with the mask |
| pc | input | AW | Current program counter, compared with the top address |
| pop_req | input | 1 | Explicit pop of the top entries |
| active_mask | output | LANES | Lanes enabled for the current instruction |
| rc_target | output | AW | Address on top of the address stack, zero when empty |
| all_inactive | output | 1 | High when no lane is enabled |
| overflow | output | 1 | Sticky: a push hit a full stack |
| underflow | output | 1 | Sticky: a pop hit an empty stack |

## Verification
The bench builds the block with DEPTH of 4 and a 16-bit address, keeping the full 32 lanes. The shallow stack makes the full condition, dropped pushes, and a push paired with a pop on a full stack reachable in a handful of cycles. The narrow address lets a random phase hit program-counter matches often, so matched pops, explicit pops and pushes interleave at every depth from empty to full. All of this is compared against a queue model on every clock.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lms_ctrl.sv
module lms_ctrl #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] cnt_q,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic          ovf_q,
  output logic          unf_q
);
  import lms_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  stk_op_e       op;
  logic          ovf_set, unf_set;
  logic [CW-1:0] cnt_d;

  // pop resolves before push
  always_comb begin
    op      = STK_HOLD;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    case ({pop, push})
      2'b11: begin
        if (cnt_q == '0) begin
          unf_set = 1'b1;
          op      = STK_PUSH;
        end else begin
          op      = STK_SWAP;
        end
      end
      2'b10: begin
        if (cnt_q == '0) unf_set = 1'b1;
        else             op      = STK_POP;
      end
      2'b01: begin
        if (cnt_q == FULL) ovf_set = 1'b1;
        else               op      = STK_PUSH;
      end
      default: op = STK_HOLD;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (op == STK_PUSH) cnt_d = cnt_q + CW'(1);
    if (op == STK_POP)  cnt_d = cnt_q - CW'(1);
  end

  assign wr_en  = (op == STK_PUSH) || (op == STK_SWAP);
  assign wr_idx = (op == STK_PUSH) ? PW'(cnt_q) : PW'(cnt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ovf_set) ovf_q <= 1'b1;
      if (unf_set) unf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lms_lifo.sv
module lms_lifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] ridx_top,
  input  logic [PW-1:0] ridx_nxt,
  output logic [W-1:0]  rd_top,
  output logic [W-1:0]  rd_nxt
);
  logic [W-1:0] mem [DEPTH];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rd_top = mem[ridx_top];
  assign rd_nxt = mem[ridx_nxt];
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_pred,
  input  logic [AW-1:0]    br_target,
  input  logic [AW-1:0]    pc,
  input  logic             pop_req,
  output logic [LANES-1:0] active_mask,
  output logic [AW-1:0]    rc_target,
  output logic             all_inactive,
  output logic             overflow,
  output logic             underflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]    cnt_q;
  logic             wr_en;
  logic [PW-1:0]    wr_idx;
  logic [PW-1:0]    idx_top, idx_nxt;
  logic [LANES-1:0] m_top, m_nxt;
  logic [AW-1:0]    a_top, a_nxt;
  logic             have_one, have_two, pc_hit, do_pop;

  assign have_one = (cnt_q != '0);
  assign have_two = (cnt_q > CW'(1));
  assign idx_top  = PW'(cnt_q - CW'(1));
  assign idx_nxt  = PW'(cnt_q - CW'(2));
  assign pc_hit   = have_one && (pc == a_top);
  assign do_pop   = pop_req || pc_hit;

  lms_ctrl #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .push(br_valid), .pop(do_pop),
    .cnt_q(cnt_q), .wr_en(wr_en), .wr_idx(wr_idx),
    .ovf_q(overflow), .unf_q(underflow)
  );

  lms_lifo #(.W(LANES), .DEPTH(DEPTH), .PW(PW)) u_masks (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(br_pred),
    .ridx_top(idx_top), .ridx_nxt(idx_nxt),
    .rd_top(m_top), .rd_nxt(m_nxt)
  );

  lms_lifo #(.W(AW), .DEPTH(DEPTH), .PW(PW)) u_addrs (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(br_target),
    .ridx_top(idx_top), .ridx_nxt(idx_nxt),
    .rd_top(a_top), .rd_nxt(a_nxt)
  );

  always_comb begin
    if (!have_one)     active_mask = '1;
    else if (have_two) active_mask = m_top & m_nxt;
    else               active_mask = m_top;
  end

  assign rc_target    = have_one ? a_top : '0;
  assign all_inactive = ~|active_mask;
endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             br_valid,
  input logic [AW-1:0]    br_target,
  input logic [AW-1:0]    pc,
  input logic             pop_req,
  input logic [LANES-1:0] active_mask,
  input logic [AW-1:0]    rc_target,
  input logic             all_inactive,
  input logic             overflow,
  input logic             underflow,
  input logic [CW-1:0]    cnt
);
  logic pop_now;
  assign pop_now = pop_req || ((cnt != '0) && (pc == rc_target));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!overflow && !underflow && active_mask == '1 && cnt == '0));

  assert_push_target_R2: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !pop_now && cnt < CW'(DEPTH)) |=> (rc_target == $past(br_target)));

  assert_match_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (!br_valid && cnt != '0 && pc == rc_target) |=> (cnt == $past(cnt) - CW'(1)));

  assert_underflow_set_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt == '0) |=> underflow);

  assert_underflow_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !pop_now && cnt == CW'(DEPTH)) |=> (overflow && cnt == CW'(DEPTH)));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_swap_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (br_valid && pop_now && cnt != '0) |=>
      (cnt == $past(cnt) && rc_target == $past(br_target) && $stable(overflow)));

  assert_idle_flag_R8: assert property (@(posedge clk) disable iff (rst)
    all_inactive == (active_mask == '0));

  assert_empty_view_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> (active_mask == '1 && rc_target == '0));
endmodule

bind lane_mask_stack lms_chk #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .br_valid(br_valid), .br_target(br_target),
  .pc(pc), .pop_req(pop_req), .active_mask(active_mask),
  .rc_target(rc_target), .all_inactive(all_inactive),
  .overflow(overflow), .underflow(underflow), .cnt(cnt_q)
);

// File: tb/tb_lane_mask_stack.sv
module tb_lane_mask_stack;
  localparam int LANES = 32;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam logic [AW-1:0] IDLE_PC = 16'hFFFF;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_pred = '0;
  logic [AW-1:0]    br_target = '0;
  logic [AW-1:0]    pc = IDLE_PC;
  logic             pop_req = 1'b0;
  logic [LANES-1:0] active_mask;
  logic [AW-1:0]    rc_target;
  logic             all_inactive, overflow, underflow;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [LANES-1:0] mq[$];
  logic [AW-1:0]    aq[$];
  bit m_ovf = 0, m_unf = 0;

  always #5 clk = ~clk;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_pred(br_pred),
    .br_target(br_target), .pc(pc), .pop_req(pop_req),
    .active_mask(active_mask), .rc_target(rc_target),
    .all_inactive(all_inactive), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [LANES-1:0] exp_mask();
    if (mq.size() == 0) return '1;
    if (mq.size() == 1) return mq[$];
    return mq[$] & mq[$-1];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    logic [LANES-1:0] em;
    logic [AW-1:0]    et;
    em = exp_mask();
    et = (aq.size() == 0) ? '0 : aq[$];
    chk(active_mask == em, tag, "active_mask", 64'(active_mask), 64'(em));
    chk(rc_target == et, tag, "rc_target", 64'(rc_target), 64'(et));
    chk(all_inactive == (em == '0), "R8", "all_inactive", 64'(all_inactive), 64'(em == '0));
    chk(overflow == m_ovf, tag, "overflow", 64'(overflow), 64'(m_ovf));
    chk(underflow == m_unf, tag, "underflow", 64'(underflow), 64'(m_unf));
  endtask

  // one clock: drive, let the edge happen, update the model, compare
  task automatic step(input bit bv, input logic [LANES-1:0] pr, input logic [AW-1:0] tg,
                      input logic [AW-1:0] pcv, input bit prq, input string tag);
    bit pop;
    br_valid = bv; br_pred = pr; br_target = tg; pc = pcv; pop_req = prq;
    pop = prq || (aq.size() != 0 && pcv == aq[$]);
    @(posedge clk);
    if (pop) begin
      if (aq.size() != 0) begin void'(mq.pop_back()); void'(aq.pop_back()); end
      else m_unf = 1;
    end
    if (bv) begin
      if (aq.size() < DEPTH) begin mq.push_back(pr); aq.push_back(tg); end
      else m_ovf = 1;
    end
    @(negedge clk);
    br_valid = 0; pop_req = 0; pc = IDLE_PC;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    mq.delete(); aq.delete(); m_ovf = 0; m_unf = 0;
    compare("R1");
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    compare("R9");
    // nested divergence
    step(1, 32'h0000FFFF, 16'h0040, 16'h0010, 0, "R2");
    step(1, 32'h00FF00FF, 16'h0030, 16'h0014, 0, "R3");
    step(1, 32'h00000000, 16'h0020, 16'h0018, 0, "R8");
    // reconvergence by program counter, innermost first
    step(0, '0, '0, 16'h0020, 0, "R4");
    step(0, '0, '0, 16'h0030, 0, "R4");
    step(0, '0, '0, 16'h0040, 0, "R9");
    // explicit pop on empty
    step(0, '0, '0, IDLE_PC, 1, "R5");
    step(0, '0, '0, IDLE_PC, 0, "R5");
    // explicit pop on non-empty
    step(1, 32'hA5A5A5A5, 16'h0100, IDLE_PC, 0, "R2");
    step(0, '0, '0, IDLE_PC, 1, "R5");
    // fill, then swap on full, then overflow
    for (int i = 0; i < DEPTH; i++)
      step(1, 32'hFFFF0000 | 32'(i), 16'(16'h0200 + i), IDLE_PC, 0, "R2");
    step(1, 32'h12345678, 16'h0300, IDLE_PC, 1, "R7");
    step(1, 32'h0F0F0F0F, 16'h0301, 16'h0300, 0, "R7");
    step(1, 32'hDEADBEEF, 16'h0400, IDLE_PC, 0, "R6");
    step(0, '0, '0, IDLE_PC, 0, "R6");
    // push plus pop on an empty stack
    do_reset();
    step(1, 32'h0000000F, 16'h0500, IDLE_PC, 1, "R7");
    // random interleaving
    do_reset();
    for (int i = 0; i < 400; i++) begin
      bit bv, prq;
      logic [LANES-1:0] pr;
      bv  = ($urandom_range(0, 99) < 45);
      prq = ($urandom_range(0, 99) < 8);
      pr  = $urandom();
      if ($urandom_range(0, 3) == 0) pr = pr & 32'h0000FFFF;
      step(bv, pr, 16'($urandom_range(1, 8)), 16'($urandom_range(0, 15)), prq, "R3");
    end
    do_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule